// File: doc/BRIEF.md
# Three-Port Grouped Parallel I/O

This block gives a host 24 general-purpose I/O lines, organised as three 8-bit ports called A, B and C. Port C is split into an upper and a lower nibble. Each nibble is controlled as its own section, so that it can later serve as handshake lines. Control is divided between two groups. The first group owns port A and the upper half of port C. The second group owns port B and the lower half of port C.

The host uses a small register bus with a select, write and read strobe, a 2-bit address and a byte of data. A control word sets the direction of each of the four sections. Data writes load output latches, and those latches drive the pins whenever their section is an output. A read returns one of two values:
- the latch, for a section configured as output;
- the pin value after a two-flop synchroniser, for a section configured as input.

Only plain input and output operation is provided.

Top module: `par24_io`

## Requirements
- R1: While reset is high and on the cycle after it, every section is an input: all output-enables are 0, all output latches are 0 and the read data is 0.
- R2: A write to address 3 sets the section directions from bit 0 (port A), bit 1 (port B), bit 2 (port C upper nibble) and bit 3 (port C lower nibble), where 1 means input and 0 means output. From the next cycle, each line's output-enable is 1 exactly when its section is an output.
- R3: A write to address 3 clears all three output latches to zero, and the pin outputs show zero on the next cycle.
- R4: A write to address 0, 1 or 2 loads the latch of port A, B or C, and the pin outputs show it on the next cycle. A port configured as input still loads its latch, but its output-enables stay 0.
- R5: A read of address 0, 1 or 2 for a section configured as output returns that section's latch in the bus read data one cycle after the read strobe.
- R6: For a section configured as input, a read returns the pin value held two clock edges before the edge that takes the read, because the pins pass through two flip-flops.
- R7: The two halves of port C are independent. Each nibble of a port C read and each nibble of pc_oe follows only that nibble's own direction bit.
- R8: A read of address 3 returns the four direction bits in bits 3:0 in their control-word positions, with zero above them.
- R9: The read data holds its value until the next read. With no write, the latches and output-enables do not change. When write and read are both high, only the write takes place.
- R10: While bus_sel is low, the write and read strobes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register bus select |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 2 | Register address: 0 = A, 1 = B, 2 = C, 3 = control |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| pa_in | input | 8 | Port A pin input |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A output-enable |
| pb_in | input | 8 | Port B pin input |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B output-enable |
| pc_in | input | 8 | Port C pin input |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C output-enable |

## Verification
The assertions assume that the bus inputs are steady around each rising clock edge. They also assume that the pins are driven by something else only where the output-enable is low. The stimulus changes every bus signal and every pin value on the falling edge, and it never drives a pin against an enabled output in a way the checks would read back. Some cycles raise the write and read strobes together, and some raise them with the select low, to cover R9 and R10.

// File: rtl/par24_pkg.sv
package par24_pkg;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_A    = 2'd0,
    SEL_B    = 2'd1,
    SEL_C    = 2'd2,
    SEL_CTRL = 2'd3
  } reg_sel_e;

  localparam int DIR_A_BIT  = 0;
  localparam int DIR_B_BIT  = 1;
  localparam int DIR_CH_BIT = 2;
  localparam int DIR_CL_BIT = 3;

  typedef struct packed {
    logic wr_a;
    logic wr_b;
    logic wr_c;
    logic wr_ctrl;
    logic rd;
  } bus_cmd_t;
endpackage

// File: rtl/par24_decode.sv
module par24_decode
  import par24_pkg::*;
(
  input  logic              sel,
  input  logic              wr,
  input  logic              rd,
  input  logic [ADDR_W-1:0] addr,
  output bus_cmd_t          cmd,
  output reg_sel_e          rd_sel
);
  logic wr_hit;

  always_comb begin
    // a write wins when both strobes are high
    wr_hit      = sel && wr;
    cmd.wr_a    = wr_hit && (addr == SEL_A);
    cmd.wr_b    = wr_hit && (addr == SEL_B);
    cmd.wr_c    = wr_hit && (addr == SEL_C);
    cmd.wr_ctrl = wr_hit && (addr == SEL_CTRL);
    cmd.rd      = sel && rd && !wr;
    rd_sel      = reg_sel_e'(addr);
  end
endmodule

// File: rtl/par24_group.sv
module par24_group #(
  parameter int DW       = 8,
  parameter int FULL_BIT = 0,
  parameter int HALF_BIT = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctrl_wr,
  input  logic [DW-1:0] ctrl_word,
  output logic          dir_full,
  output logic          dir_half,
  output logic          clr
);
  logic full_q, half_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= 1'b1;
      half_q <= 1'b1;
    end else if (ctrl_wr) begin
      full_q <= ctrl_word[FULL_BIT];
      half_q <= ctrl_word[HALF_BIT];
    end
  end

  assign dir_full = full_q;
  assign dir_half = half_q;
  assign clr      = ctrl_wr;
endmodule

// File: rtl/par24_lane.sv
module par24_lane #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         ld,
  input  logic         clr,
  input  logic [W-1:0] ld_val,
  input  logic         dir_in,
  input  logic [W-1:0] pin_i,
  output logic [W-1:0] pin_o,
  output logic [W-1:0] pin_oe,
  output logic [W-1:0] rd_val
);
  logic [W-1:0] latch_q, sync1_q, sync2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_q <= '0;
    end else if (clr) begin
      latch_q <= '0;
    end else if (ld) begin
      latch_q <= ld_val;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1_q <= '0;
      sync2_q <= '0;
    end else begin
      sync1_q <= pin_i;
      sync2_q <= sync1_q;
    end
  end

  assign pin_o  = latch_q;
  assign pin_oe = {W{~dir_in}};
  assign rd_val = dir_in ? sync2_q : latch_q;
endmodule

// File: rtl/par24_io.sv
module par24_io
  import par24_pkg::*;
#(
  parameter int PORT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [1:0]        bus_addr,
  input  logic [PORT_W-1:0] bus_wdata,
  output logic [PORT_W-1:0] bus_rdata,
  input  logic [PORT_W-1:0] pa_in,
  output logic [PORT_W-1:0] pa_out,
  output logic [PORT_W-1:0] pa_oe,
  input  logic [PORT_W-1:0] pb_in,
  output logic [PORT_W-1:0] pb_out,
  output logic [PORT_W-1:0] pb_oe,
  input  logic [PORT_W-1:0] pc_in,
  output logic [PORT_W-1:0] pc_out,
  output logic [PORT_W-1:0] pc_oe
);
  localparam int HALF_W = PORT_W / 2;
  localparam int NGRP   = 2;

  bus_cmd_t cmd;
  reg_sel_e rd_sel;

  par24_decode u_dec (
    .sel(bus_sel), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
    .cmd(cmd), .rd_sel(rd_sel)
  );

  logic [NGRP-1:0] dir_full, dir_half, grp_clr, full_ld;
  logic [NGRP-1:0][PORT_W-1:0] full_in, full_out, full_oe, full_rd;
  logic [NGRP-1:0][HALF_W-1:0] half_in, half_out, half_oe, half_rd, half_val;

  assign full_ld    = {cmd.wr_b, cmd.wr_a};
  assign full_in[0] = pa_in;
  assign full_in[1] = pb_in;

  // group 0: port A + upper nibble of C; group 1: port B + lower nibble of C
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam int FB   = (g == 0) ? DIR_A_BIT  : DIR_B_BIT;
    localparam int HB   = (g == 0) ? DIR_CH_BIT : DIR_CL_BIT;
    localparam int BASE = (NGRP - 1 - g) * HALF_W;

    par24_group #(.DW(PORT_W), .FULL_BIT(FB), .HALF_BIT(HB)) u_grp (
      .clk(clk), .rst(rst), .ctrl_wr(cmd.wr_ctrl), .ctrl_word(bus_wdata),
      .dir_full(dir_full[g]), .dir_half(dir_half[g]), .clr(grp_clr[g])
    );

    par24_lane #(.W(PORT_W)) u_full (
      .clk(clk), .rst(rst), .ld(full_ld[g]), .clr(grp_clr[g]),
      .ld_val(bus_wdata), .dir_in(dir_full[g]), .pin_i(full_in[g]),
      .pin_o(full_out[g]), .pin_oe(full_oe[g]), .rd_val(full_rd[g])
    );

    assign half_in[g]  = pc_in[BASE +: HALF_W];
    assign half_val[g] = bus_wdata[BASE +: HALF_W];

    par24_lane #(.W(HALF_W)) u_half (
      .clk(clk), .rst(rst), .ld(cmd.wr_c), .clr(grp_clr[g]),
      .ld_val(half_val[g]), .dir_in(dir_half[g]), .pin_i(half_in[g]),
      .pin_o(half_out[g]), .pin_oe(half_oe[g]), .rd_val(half_rd[g])
    );
  end

  assign pa_out = full_out[0];
  assign pa_oe  = full_oe[0];
  assign pb_out = full_out[1];
  assign pb_oe  = full_oe[1];
  assign pc_out = {half_out[0], half_out[1]};
  assign pc_oe  = {half_oe[0], half_oe[1]};

  logic [PORT_W-1:0] ctrl_view;
  always_comb begin
    ctrl_view             = '0;
    ctrl_view[DIR_A_BIT]  = dir_full[0];
    ctrl_view[DIR_B_BIT]  = dir_full[1];
    ctrl_view[DIR_CH_BIT] = dir_half[0];
    ctrl_view[DIR_CL_BIT] = dir_half[1];
  end

  logic [PORT_W-1:0] rdata_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (cmd.rd) begin
      case (rd_sel)
        SEL_A:   rdata_q <= full_rd[0];
        SEL_B:   rdata_q <= full_rd[1];
        SEL_C:   rdata_q <= {half_rd[0], half_rd[1]};
        default: rdata_q <= ctrl_view;
      endcase
    end
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/par24_io_chk.sv
module par24_io_chk #(
  parameter int PORT_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [1:0]        bus_addr,
  input logic [PORT_W-1:0] bus_wdata,
  input logic [PORT_W-1:0] bus_rdata,
  input logic [PORT_W-1:0] pa_out,
  input logic [PORT_W-1:0] pa_oe,
  input logic [PORT_W-1:0] pb_out,
  input logic [PORT_W-1:0] pb_oe,
  input logic [PORT_W-1:0] pc_out,
  input logic [PORT_W-1:0] pc_oe
);
  localparam int H = PORT_W / 2;

  logic ctl_w, a_w, any_w, rd_go;
  assign ctl_w = bus_sel && bus_wr && (bus_addr == 2'd3);
  assign a_w   = bus_sel && bus_wr && (bus_addr == 2'd0);
  assign any_w = bus_sel && bus_wr;
  assign rd_go = bus_sel && bus_rd && !bus_wr;

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (pa_oe == '0 && pb_oe == '0 && pc_oe == '0 && bus_rdata == '0));

  // R2
  cfg_oe_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_w |=> (pa_oe == {PORT_W{~$past(bus_wdata[0])}} &&
               pb_oe == {PORT_W{~$past(bus_wdata[1])}} &&
               pc_oe == {{H{~$past(bus_wdata[2])}}, {H{~$past(bus_wdata[3])}}}));

  // R3
  cfg_clear_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_w |=> (pa_out == '0 && pb_out == '0 && pc_out == '0));

  // R4
  load_a_chk: assert property (@(posedge clk) disable iff (rst)
    a_w |=> (pa_out == $past(bus_wdata)));

  // R7
  half_oe_chk: assert property (@(posedge clk) disable iff (rst)
    (($countones(pc_oe[H-1:0]) == 0) || ($countones(pc_oe[H-1:0]) == H)) &&
    (($countones(pc_oe[PORT_W-1:H]) == 0) || ($countones(pc_oe[PORT_W-1:H]) == H)));

  // R8
  ctrl_read_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_go && bus_addr == 2'd3) |=> (bus_rdata[PORT_W-1:4] == '0));

  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !any_w |=> ($stable(pa_out) && $stable(pb_out) && $stable(pc_out) &&
                $stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe)));

  // R9
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !rd_go |=> $stable(bus_rdata));
endmodule

bind par24_io par24_io_chk #(.PORT_W(PORT_W)) chk_i (
  .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .pa_out(pa_out), .pa_oe(pa_oe), .pb_out(pb_out), .pb_oe(pb_oe),
  .pc_out(pc_out), .pc_oe(pc_oe)
);

// File: tb/par24_io_tb.sv
module par24_io_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYC    = 20000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       bus_sel = 0, bus_wr = 0, bus_rd = 0;
  logic [1:0] bus_addr = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic [7:0] pa_in = 0, pb_in = 0, pc_in = 0;
  logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit live = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  par24_io dut_i (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
    .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
    .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
  );

  // behavioural reference model
  logic [3:0] m_dir;
  logic [7:0] m_la, m_lb, m_lc, m_rd;
  logic [7:0] ha1, ha2, hb1, hb2, hc1, hc2;

  function automatic logic [7:0] m_read(input logic [1:0] a);
    case (a)
      2'd0: return m_dir[0] ? ha2 : m_la;
      2'd1: return m_dir[1] ? hb2 : m_lb;
      2'd2: return {m_dir[2] ? hc2[7:4] : m_lc[7:4], m_dir[3] ? hc2[3:0] : m_lc[3:0]};
      default: return {4'b0, m_dir};
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_dir = 4'hF; m_la = 0; m_lb = 0; m_lc = 0; m_rd = 0;
      ha1 = 0; ha2 = 0; hb1 = 0; hb2 = 0; hc1 = 0; hc2 = 0;
    end else begin
      if (bus_sel && bus_rd && !bus_wr) m_rd = m_read(bus_addr);
      if (bus_sel && bus_wr) begin
        case (bus_addr)
          2'd0: m_la = bus_wdata;
          2'd1: m_lb = bus_wdata;
          2'd2: m_lc = bus_wdata;
          default: begin m_dir = bus_wdata[3:0]; m_la = 0; m_lb = 0; m_lc = 0; end
        endcase
      end
      ha2 = ha1; ha1 = pa_in;
      hb2 = hb1; hb1 = pb_in;
      hc2 = hc1; hc1 = pc_in;
    end
    live = 1;
  end

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", req, act, exp, $time);
    end
  endtask

  // compare against the model on every falling edge
  always @(negedge clk) begin
    if (live && !done) begin
      check("R3/R4 pa_out", pa_out, m_la);
      check("R3/R4 pb_out", pb_out, m_lb);
      check("R3/R4 pc_out", pc_out, m_lc);
      check("R2 pa_oe", pa_oe, {8{~m_dir[0]}});
      check("R2 pb_oe", pb_oe, {8{~m_dir[1]}});
      check("R2/R7 pc_oe", pc_oe, {{4{~m_dir[2]}}, {4{~m_dir[3]}}});
      check("R5/R6 rdata", bus_rdata, m_rd);
    end
  end

  task automatic bus_op(input logic s, input logic w, input logic r,
                        input logic [1:0] a, input logic [7:0] d);
    bus_sel = s; bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; bus_rd = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (MAX_CYC) @(posedge clk);
    if (!done) begin
      done = 1;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state while reset is held
    check("R1 oe", pa_oe | pb_oe | pc_oe, 8'h00);
    check("R1 out", pa_out | pb_out | pc_out, 8'h00);
    check("R1 rdata", bus_rdata, 8'h00);
    rst = 0;
    idle(1);
    // R8: control view after reset is all inputs
    bus_op(1, 0, 1, 2'd3, 0);
    check("R8 ctrl read", bus_rdata, 8'h0F);
    // R6: input read through sync
    pa_in = 8'h5A; pb_in = 8'hC3; pc_in = 8'h96;
    idle(3);
    bus_op(1, 0, 1, 2'd0, 0);
    check("R6 read A pins", bus_rdata, 8'h5A);
    // R6: a pin change one edge before the read is not yet visible
    pa_in = 8'h11;
    bus_op(1, 0, 1, 2'd0, 0);
    check("R6 sync delay", bus_rdata, 8'h5A);
    // R4: write to input port loads latch, no drive
    bus_op(1, 1, 0, 2'd0, 8'h33);
    check("R4 latch on input port", pa_out, 8'h33);
    check("R4 oe stays low", pa_oe, 8'h00);
    // R10: strobes without select do nothing
    bus_op(0, 1, 0, 2'd0, 8'hEE);
    check("R10 ignored write", pa_out, 8'h33);
    bus_op(0, 1, 0, 2'd3, 8'h00);
    check("R10 ignored ctrl", pa_oe, 8'h00);
    // R3, R2: all outputs
    bus_op(1, 1, 0, 2'd3, 8'h00);
    check("R3 clear", pa_out | pb_out | pc_out, 8'h00);
    check("R2 all out", pa_oe & pb_oe & pc_oe, 8'hFF);
    // R5: read back latches
    bus_op(1, 1, 0, 2'd1, 8'hA7);
    bus_op(1, 0, 1, 2'd1, 0);
    check("R5 read B latch", bus_rdata, 8'hA7);
    // R7: upper C input, lower C output
    bus_op(1, 1, 0, 2'd3, 8'h04);
    check("R7 pc_oe split", pc_oe, 8'h0F);
    bus_op(1, 1, 0, 2'd2, 8'h4D);
    pc_in = 8'hB2;
    idle(3);
    bus_op(1, 0, 1, 2'd2, 0);
    check("R7 mixed C read", bus_rdata, 8'hBD);
    // R9: write and read together -> only write
    bus_op(1, 1, 1, 2'd1, 8'h5C);
    check("R9 write wins", pb_out, 8'h5C);
    check("R9 rdata held", bus_rdata, 8'hBD);
    idle(4);
    check("R9 idle hold", pb_out, 8'h5C);
    // randomised traffic
    for (int i = 0; i < 600; i++) begin
      pa_in = 8'($urandom); pb_in = 8'($urandom); pc_in = 8'($urandom);
      case ($urandom_range(0, 7))
        0: bus_op(1, 1, 0, 2'd3, 8'($urandom));
        1, 2: bus_op(1, 1, 0, 2'($urandom), 8'($urandom));
        3, 4, 5: bus_op(1, 0, 1, 2'($urandom), 8'($urandom));
        6: bus_op(1'($urandom), 1'($urandom), 1'($urandom), 2'($urandom), 8'($urandom));
        default: idle(1);
      endcase
    end
    idle(2);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule